// File: doc/BRIEF.md
# Serial Clock Mode Detector

This block sits at the serial audio input of a stereo converter. It runs entirely on the master clock. It decides whether the bit clock comes from outside the chip or must be made inside. Both the incoming bit clock and the left/right frame clock are first passed through two-flop synchronizers. The block then counts rising edges of the bit clock between consecutive frame-clock edges. When sixteen edges arrive within one such segment, the block selects the external bit clock. When a segment closes with fewer than sixteen, it returns to the internal clock.

In internal mode the block measures the frame period in master-clock cycles at each falling frame-clock edge. It then divides the master clock to produce exactly 64 bit-clock periods per frame with a 50% duty cycle. An optional divide-by-two halves the master clock before the divider and before the speed decision. The divider restarts low at every frame-clock edge, so any rounding in the divider never builds up into drift. The measured ratio also gives a double-speed flag. A one-cycle strobe marks the start of each frame.

Top module: `sclk_mode_detect`

## Requirements
- R1: While and after reset, before any input activity, ext_mode, bclk_out, dbl_speed and sample_strobe are all 0.
- R2: ext_mode rises on the third master-clock cycle after the input sample that carries the 16th bit-clock rising edge since the last frame-clock edge. While ext_mode is 1, bclk_out equals the external bit clock delayed by two master-clock cycles.
- R3: The edge count restarts at every frame-clock edge, rising or falling. Segments with at most 15 bit-clock rising edges each never set ext_mode, even when a whole frame holds more than 16.
- R4: A frame-clock edge that closes a segment with fewer than 16 bit-clock rises clears ext_mode. A segment with 16 or more keeps ext_mode at 1 through the next segment.
- R5: In internal mode, bclk_out is low on the cycle after every frame-clock edge. It makes exactly 64 rising edges per frame.
- R6: With a frame period of N master-clock cycles, where N divided by 128 (or by 256 when divide-by-two is on) is a whole number, every high and low phase of the internal bclk_out lasts N/128 master-clock cycles.
- R7: With div2_en at 1, the effective ratio used for the divider and the speed flag is N/2 instead of N.
- R8: At each falling frame-clock edge, dbl_speed is set to 1 when the effective ratio is below 256 and to 0 otherwise.
- R9: sample_strobe is a one-cycle pulse, once per frame, on the falling edge of the frame clock (frame clock low is the first channel of a frame).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_ext | input | 1 | Bit clock from outside, asynchronous |
| lrck | input | 1 | Left/right frame clock, asynchronous |
| div2_en | input | 1 | Halve the master clock before use |
| bclk_out | output | 1 | Selected bit clock |
| ext_mode | output | 1 | 1 = external bit clock selected |
| dbl_speed | output | 1 | 1 = double-speed ratio measured |
| sample_strobe | output | 1 | One-cycle pulse at frame start |

## Verification
The bench drives exactly 15 and then exactly 16 rising edges into a segment. It checks the exact cycle at which the mode flips. A design that counts across frame edges, or is off by one at the threshold, would switch one segment early or one edge late. It also sends a short segment after external mode and checks that the flag falls only at the following edge, not at the one before. A design that decides on the wrong segment keeps the external clock after it is gone. A sweep over nine ratio and divider settings checks rise counts, every phase width, strobes and the speed flag. A divider that drifts, is not realigned at frame edges, or ignores the divide-by-two would show wrong run lengths or 63 or 65 rises per frame.

// File: rtl/sclk_mode_pkg.sv
package sclk_mode_pkg;

    typedef enum logic {
        BCLK_INTERNAL = 1'b0,
        BCLK_EXTERNAL = 1'b1
    } bclk_src_e;

    typedef struct packed {
        logic bclk;
        logic lrck;
    } pin_pair_t;

    typedef struct packed {
        logic bclk_rise;
        logic frame_edge;
        logic frame_fall;
    } port_evt_t;

endpackage

// File: rtl/sclk_mode_sync.sv
module sclk_mode_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        logic stable;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta   <= 1'b0;
                stable <= 1'b0;
            end else begin
                meta   <= d[i];
                stable <= meta;
            end
        end
        assign q[i] = stable;
    end
endmodule

// File: rtl/sclk_mode_events.sv
module sclk_mode_events
    import sclk_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_pair_t syn,
    output port_evt_t ev
);
    pin_pair_t last;

    always_ff @(posedge clk) begin
        if (rst) last <= '0;
        else     last <= syn;
    end

    always_comb begin
        ev.bclk_rise  = syn.bclk & ~last.bclk;
        ev.frame_edge = syn.lrck ^ last.lrck;
        ev.frame_fall = ~syn.lrck & last.lrck;
    end
endmodule

// File: rtl/sclk_mode_judge.sv
module sclk_mode_judge
    import sclk_mode_pkg::*;
#(
    parameter int THRESH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  port_evt_t ev,
    output bclk_src_e src
);
    localparam int CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);

    logic [CW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
            src  <= BCLK_INTERNAL;
        end else if (ev.frame_edge) begin
            if (seen < LIMIT) src <= BCLK_INTERNAL;
            seen <= ev.bclk_rise ? CW'(1) : '0;
        end else if (ev.bclk_rise && seen != LIMIT) begin
            seen <= seen + CW'(1);
            if (seen == LIMIT - CW'(1)) src <= BCLK_EXTERNAL;
        end
    end
endmodule

// File: rtl/sclk_mode_intgen.sv
module sclk_mode_intgen
    import sclk_mode_pkg::*;
#(
    parameter int MEAS_W         = 12,
    parameter int BCLK_PER_FRAME = 64,
    parameter int DBL_SPLIT      = 256,
    parameter int RST_HALF       = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      div2_en,
    input  port_evt_t ev,
    output logic      bclk_int,
    output logic      dbl_speed
);
    localparam int TOG_LOG = $clog2(2 * BCLK_PER_FRAME);
    localparam int HW      = MEAS_W - TOG_LOG;
    localparam logic [MEAS_W-1:0] MEAS_MAX = '1;

    logic [MEAS_W-1:0] mcnt, period_nx, peff_nx;
    logic [HW-1:0]     half, half_nx, dcnt;
    logic              phase, ce;

    always_comb begin
        period_nx = (mcnt == MEAS_MAX) ? mcnt : mcnt + MEAS_W'(1);
        peff_nx   = div2_en ? (period_nx >> 1) : period_nx;
        half_nx   = peff_nx[MEAS_W-1:TOG_LOG];
        ce        = ~div2_en | phase;
    end

    always_ff @(posedge clk) begin
        if (rst)                   mcnt <= '0;
        else if (ev.frame_fall)    mcnt <= '0;
        else if (mcnt != MEAS_MAX) mcnt <= mcnt + MEAS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half      <= HW'(RST_HALF);
            dbl_speed <= 1'b0;
        end else if (ev.frame_fall && half_nx != '0) begin
            half      <= half_nx;
            dbl_speed <= (peff_nx < MEAS_W'(DBL_SPLIT));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ev.frame_edge) phase <= 1'b0;
        else                      phase <= ~phase;
    end

    always_ff @(posedge clk) begin
        if (rst || ev.frame_edge) begin
            dcnt     <= '0;
            bclk_int <= 1'b0;
        end else if (ce) begin
            if (dcnt == half - HW'(1)) begin
                dcnt     <= '0;
                bclk_int <= ~bclk_int;
            end else begin
                dcnt <= dcnt + HW'(1);
            end
        end
    end
endmodule

// File: rtl/sclk_mode_detect.sv
module sclk_mode_detect
    import sclk_mode_pkg::*;
#(
    parameter int THRESH         = 16,
    parameter int BCLK_PER_FRAME = 64,
    parameter int MEAS_W         = 12,
    parameter int DBL_SPLIT      = 256,
    parameter int RST_HALF       = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_ext,
    input  logic lrck,
    input  logic div2_en,
    output logic bclk_out,
    output logic ext_mode,
    output logic dbl_speed,
    output logic sample_strobe
);
    pin_pair_t raw, syn;
    port_evt_t ev;
    bclk_src_e src;
    logic      bclk_int;
    logic      frame_edge, bclk_rise;

    assign raw.bclk = sclk_ext;
    assign raw.lrck = lrck;

    sclk_mode_sync #(.W($bits(pin_pair_t))) i_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    sclk_mode_events i_events (
        .clk(clk), .rst(rst), .syn(syn), .ev(ev)
    );

    sclk_mode_judge #(.THRESH(THRESH)) i_judge (
        .clk(clk), .rst(rst), .ev(ev), .src(src)
    );

    sclk_mode_intgen #(
        .MEAS_W(MEAS_W), .BCLK_PER_FRAME(BCLK_PER_FRAME),
        .DBL_SPLIT(DBL_SPLIT), .RST_HALF(RST_HALF)
    ) i_intgen (
        .clk(clk), .rst(rst), .div2_en(div2_en), .ev(ev),
        .bclk_int(bclk_int), .dbl_speed(dbl_speed)
    );

    assign frame_edge    = ev.frame_edge;
    assign bclk_rise     = ev.bclk_rise;
    assign ext_mode      = (src == BCLK_EXTERNAL);
    assign bclk_out      = ext_mode ? syn.bclk : bclk_int;
    assign sample_strobe = ev.frame_fall;
endmodule

// File: rtl/sclk_mode_detect_chk.sv
module sclk_mode_detect_chk (
    input logic clk,
    input logic rst,
    input logic ext_mode,
    input logic bclk_out,
    input logic sample_strobe,
    input logic frame_edge,
    input logic bclk_rise
);
    // R9
    strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |=> !sample_strobe);

    // R9
    strobe_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |-> frame_edge);

    // R4
    ext_fall_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_mode) |-> $past(frame_edge));

    // R2
    ext_rise_on_bclk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_mode) |-> $past(bclk_rise));

    // R5
    realign_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(frame_edge) && !ext_mode) |-> !bclk_out);
endmodule

bind sclk_mode_detect sclk_mode_detect_chk i_chk (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .bclk_out(bclk_out),
    .sample_strobe(sample_strobe), .frame_edge(frame_edge), .bclk_rise(bclk_rise)
);

// File: tb/test_sclk_mode_detect.sv
module test_sclk_mode_detect;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk_ext = 1'b0;
    logic lrck = 1'b1;
    logic div2_en = 1'b0;
    logic bclk_out, ext_mode, dbl_speed, sample_strobe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int rises, strobes, bad_runs, ext_ones, follow_mm, first_ext;
    int gi = 0, last_t;
    bit have_t, prev_b, hist1, hist2, ext_h0_200, ext_h1_20;

    always #(CLK_P/2) clk = ~clk;

    sclk_mode_detect i_sclk_mode_detect (
        .clk(clk), .rst(rst), .sclk_ext(sclk_ext), .lrck(lrck),
        .div2_en(div2_en), .bclk_out(bclk_out), .ext_mode(ext_mode),
        .dbl_speed(dbl_speed), .sample_strobe(sample_strobe)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic clear_stats();
        rises = 0; strobes = 0; bad_runs = 0; ext_ones = 0;
        follow_mm = 0; first_ext = -1; have_t = 0;
        ext_h0_200 = 0; ext_h1_20 = 0;
    endtask

    // one frame of n cycles, nr external bit-clock rises per half, exp_run 0 = no run check
    task automatic run_frame(input int n, input int nr, input int exp_run);
        for (int half = 0; half < 2; half++) begin
            for (int p = 0; p < n/2; p++) begin
                bit b, e, s, v;
                @(negedge clk);
                b = bclk_out; e = ext_mode; s = sample_strobe;
                if (b && !prev_b) rises++;
                if (s) strobes++;
                if (b != prev_b) begin
                    if (have_t && exp_run != 0 && (gi - last_t) != exp_run) bad_runs++;
                    have_t = 1; last_t = gi;
                end
                prev_b = b;
                if (e) ext_ones++;
                if (b != hist2) follow_mm++;
                if (half == 0 && e && first_ext < 0) first_ext = p;
                if (half == 0 && p == 200) ext_h0_200 = e;
                if (half == 1 && p == 20) ext_h1_20 = e;
                v = (p >= 4 && p < 4 + nr*8) ? (((p - 4) % 8) >= 4) : 1'b0;
                lrck = half[0];
                sclk_ext = v;
                hist2 = hist1; hist1 = v;
                gi++;
            end
        end
    endtask

    task automatic sweep_cfg(input int n, input bit d);
        int peff;
        peff = d ? n/2 : n;
        div2_en = d;
        for (int f = 0; f < 3; f++) run_frame(n, 0, 0);
        clear_stats();
        for (int f = 0; f < 2; f++) run_frame(n, 0, n/128);
        check($sformatf("R5 rises per 2 frames N=%0d d=%0d", n, d), rises, 128);
        check($sformatf("R6 R7 bad phase widths N=%0d d=%0d", n, d), bad_runs, 0);
        check($sformatf("R9 strobes per 2 frames N=%0d d=%0d", n, d), strobes, 2);
        check($sformatf("R8 dbl_speed N=%0d d=%0d", n, d), dbl_speed, (peff < 256) ? 1 : 0);
        check($sformatf("R3 ext idle N=%0d d=%0d", n, d), ext_ones, 0);
    endtask

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) @(negedge clk);
        check("R1 ext_mode in reset", ext_mode, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ext_mode", ext_mode, 0);
        check("R1 bclk_out", bclk_out, 0);
        check("R1 dbl_speed", dbl_speed, 0);
        check("R1 sample_strobe", sample_strobe, 0);
        prev_b = 0; hist1 = 0; hist2 = 0;

        sweep_cfg(128, 0);
        sweep_cfg(256, 0);
        sweep_cfg(384, 0);
        sweep_cfg(512, 0);
        sweep_cfg(768, 0);
        sweep_cfg(256, 1);
        sweep_cfg(512, 1);
        sweep_cfg(768, 1);
        sweep_cfg(1024, 1);

        div2_en = 0;
        run_frame(512, 0, 0);
        run_frame(512, 0, 0);

        clear_stats();
        run_frame(512, 15, 0);
        run_frame(512, 15, 0);
        check("R3 15 rises per segment keep internal", ext_ones, 0);

        clear_stats();
        run_frame(512, 16, 0);
        check("R2 ext_mode first cycle after 16th rise", first_ext, 131);
        clear_stats();
        run_frame(512, 16, 0);
        check("R2 ext_mode held over frame", ext_ones, 512);
        check("R2 bclk_out follows external clock", follow_mm, 0);

        clear_stats();
        run_frame(512, 10, 0);
        check("R4 ext kept after segment of 16", ext_h0_200, 1);
        check("R4 ext cleared after segment of 10", ext_h1_20, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule